// File: doc/BRIEF.md
# Supply Supervisor with Watchdog

This block keeps a microprocessor in reset while its supply is unusable and pulls it back into reset when its software stops responding. Two digital indications arrive from external comparators: one saying the supply is above a minimum operating level, one saying it is above the trip threshold. Reset is released only after the threshold indication has held for a fixed qualification interval. The interval is counted in millisecond ticks from an external timebase.

A watchdog counts the same ticks. Software restarts it by driving a falling edge on the pin it shares with the serial chip select. The timeout is picked by two period bits in a small status register. A write-protect pin, together with a protect-enable bit, can freeze both the period bits and the enable bit. When the watchdog expires, the block applies one full qualification interval of reset. While reset is active, a blocked flag tells the serial memory interface to refuse every command.

Top module: `supply_supervisor`

## Requirements
- R1: `reset_out` is 1 during `rst_n` low, and at any time that `vcc_above_min` or `vcc_above_trip` is 0.
- R2: `reset_out` falls only after `vcc_above_trip` and `vcc_above_min` have both been 1 across HOLD_MS ticks of `ms_tick`, 200 by default. It falls on the clock after the last of those ticks.
- R3: When either supply indication drops, `reset_out` rises in the same cycle, combinationally. The qualification count restarts from zero, even if the drop lasts only one cycle.
- R4: `cmd_block` equals `reset_out` at all times.
- R5: `cs_wdi_pin` passes through a two-flop synchronizer. Only a high-to-low transition restarts the watchdog count. A steady level or a low-to-high transition leaves the count alone.
- R6: The timeout in ticks is set by `sr_period`: 2'b00 gives PER_LONG (1400), 2'b01 gives PER_MID (600), 2'b10 gives PER_SHORT (200), and 2'b11 turns the watchdog off.
- R7: A write with `sr_wr_en` high loads `sr_period` and `sr_wpen` on the next clock. The write is ignored while `wp_pin` is 0 and `sr_wpen` is 1. After reset, `sr_period` is PERIOD_RST (2'b00) and `sr_wpen` is 0.
- R8: When the watchdog reaches its timeout, reset is asserted for the full HOLD_MS qualification interval. After release, the watchdog counts again from zero.
- R9: The watchdog count is held at zero while reset is asserted, so no timeout can occur during qualification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| vcc_above_min | input | 1 | Supply above minimum operating level |
| vcc_above_trip | input | 1 | Supply above trip threshold |
| cs_wdi_pin | input | 1 | Shared chip-select / watchdog kick pin (asynchronous) |
| wp_pin | input | 1 | Write-protect pin, 0 = protect |
| sr_wr_en | input | 1 | Status write strobe |
| sr_wr_period | input | 2 | Period bits to write |
| sr_wr_wpen | input | 1 | Protect-enable bit to write |
| sr_period | output | 2 | Current period bits |
| sr_wpen | output | 1 | Current protect-enable bit |
| reset_out | output | 1 | Processor reset, 1 = active |
| cmd_block | output | 1 | 1 = memory commands refused |

## Verification
The bench works on a small configuration: HOLD_MS of 4, and timeouts of 14, 6 and 2 ticks. It sweeps all four period codes. For each code it checks that reset stays low one tick before the timeout and rises at the timeout tick, so an off-by-one counter or a swapped decode shows up as early or late reset. It also checks that the off code never times out.

A supply glitch of one cycle in the middle of qualification must restart the full count. A design that pauses instead of clearing would release two ticks early.

The kick test checks that a falling edge restarts the count and a rising edge does not. A design that reacts to any edge would fire late after the rising edge.

Status writes are tried under every combination of the protect pin and the enable bit. This catches a lock that protects only one of the fields, or one that uses the wrong pin polarity.

// File: rtl/supsv_pkg.sv
package supsv_pkg;

  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;

endpackage

// File: rtl/supsv_cs_sync.sv
module supsv_cs_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);

  logic meta_q, sync_q, prev_q;

  // Two-flop synchronizer plus one delay stage for edge detection; idle high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign fall_o = prev_q & ~sync_q;

  assert_single_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);

endmodule

// File: rtl/supsv_status.sv
module supsv_status #(
  parameter logic [1:0] PERIOD_RST = 2'b00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  logic [1:0] wr_period_i,
  input  logic       wr_wpen_i,
  input  logic       wp_pin_i,
  output logic [1:0] period_o,
  output logic       wpen_o
);

  logic [1:0] period_q, period_d;
  logic       wpen_q, wpen_d;
  logic       locked, load;

  assign locked = ~wp_pin_i & wpen_q;
  assign load   = wr_en_i & ~locked;

  always_comb begin
    period_d = period_q;
    wpen_d   = wpen_q;
    if (load) begin
      period_d = wr_period_i;
      wpen_d   = wr_wpen_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= PERIOD_RST;
      wpen_q   <= 1'b0;
    end else begin
      period_q <= period_d;
      wpen_q   <= wpen_d;
    end
  end

  assign period_o = period_q;
  assign wpen_o   = wpen_q;

  assert_lock_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wp_pin_i && wpen_q) |=> ($stable(period_q) && $stable(wpen_q)));

endmodule

// File: rtl/supsv_reset_qual.sv
module supsv_reset_qual #(
  parameter int HOLD_MS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic supply_ok_i,
  input  logic wd_expire_i,
  output logic rst_active_o
);

  localparam int HW = $clog2(HOLD_MS + 1);
  localparam logic [HW-1:0] HOLD_END = HW'(HOLD_MS);

  logic [HW-1:0] hold_q, hold_d;
  logic          qualified;

  assign qualified = (hold_q == HOLD_END);

  always_comb begin
    hold_d = hold_q;
    if (!supply_ok_i || wd_expire_i) begin
      hold_d = '0;
    end else if (tick_i && !qualified) begin
      hold_d = hold_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign rst_active_o = ~supply_ok_i | ~qualified;

  assert_drop_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok_i |=> (hold_q == '0));

  assert_release_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_active_o) |-> $past(tick_i));

  assert_expire_rehold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire_i |=> rst_active_o);

endmodule

// File: rtl/supsv_wdog.sv
module supsv_wdog
  import supsv_pkg::*;
#(
  parameter int PER_LONG  = 1400,
  parameter int PER_MID   = 600,
  parameter int PER_SHORT = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       hold_clr_i,
  input  logic       kick_i,
  input  logic [1:0] period_i,
  output logic       expire_o
);

  localparam int MAXP = (PER_LONG > PER_MID) ?
                        ((PER_LONG > PER_SHORT) ? PER_LONG : PER_SHORT) :
                        ((PER_MID > PER_SHORT) ? PER_MID : PER_SHORT);
  localparam int CW = $clog2(MAXP + 1);

  logic [CW-1:0] cnt_q, cnt_d, last;
  logic          enabled;

  always_comb begin
    enabled = 1'b1;
    last    = '0;
    case (wd_sel_e'(period_i))
      WD_LONG:  last = CW'(PER_LONG - 1);
      WD_MID:   last = CW'(PER_MID - 1);
      WD_SHORT: last = CW'(PER_SHORT - 1);
      default:  enabled = 1'b0;
    endcase
  end

  assign expire_o = tick_i & enabled & ~hold_clr_i & ~kick_i & (cnt_q == last);

  always_comb begin
    cnt_d = cnt_q;
    if (hold_clr_i || kick_i || !enabled || expire_o) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_held_in_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_clr_i |=> (cnt_q == '0));

  assert_kick_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> (cnt_q == '0));

  assert_off_never_fires_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (period_i == 2'b11) |-> !expire_o);

endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor #(
  parameter int         HOLD_MS    = 200,
  parameter int         PER_LONG   = 1400,
  parameter int         PER_MID    = 600,
  parameter int         PER_SHORT  = 200,
  parameter logic [1:0] PERIOD_RST = 2'b00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       vcc_above_min,
  input  logic       vcc_above_trip,
  input  logic       cs_wdi_pin,
  input  logic       wp_pin,
  input  logic       sr_wr_en,
  input  logic [1:0] sr_wr_period,
  input  logic       sr_wr_wpen,
  output logic [1:0] sr_period,
  output logic       sr_wpen,
  output logic       reset_out,
  output logic       cmd_block
);

  logic supply_ok, kick, wd_expire, rst_active;

  assign supply_ok = vcc_above_min & vcc_above_trip;

  supsv_cs_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (cs_wdi_pin),
    .fall_o (kick)
  );

  supsv_status #(.PERIOD_RST(PERIOD_RST)) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (sr_wr_en),
    .wr_period_i (sr_wr_period),
    .wr_wpen_i   (sr_wr_wpen),
    .wp_pin_i    (wp_pin),
    .period_o    (sr_period),
    .wpen_o      (sr_wpen)
  );

  supsv_reset_qual #(.HOLD_MS(HOLD_MS)) u_qual (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (ms_tick),
    .supply_ok_i  (supply_ok),
    .wd_expire_i  (wd_expire),
    .rst_active_o (rst_active)
  );

  supsv_wdog #(
    .PER_LONG  (PER_LONG),
    .PER_MID   (PER_MID),
    .PER_SHORT (PER_SHORT)
  ) u_wdog (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (ms_tick),
    .hold_clr_i (rst_active),
    .kick_i     (kick),
    .period_i   (sr_period),
    .expire_o   (wd_expire)
  );

  assign reset_out = rst_active;
  assign cmd_block = rst_active;

  assert_min_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_above_min |-> reset_out);

endmodule

// File: tb/supply_supervisor_bench.sv
module supply_supervisor_bench;

  localparam int HOLD = 4;
  localparam int PL = 14, PM = 6, PS = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic       vcc_above_min = 1'b1;
  logic       vcc_above_trip = 1'b1;
  logic       cs_wdi_pin = 1'b1;
  logic       wp_pin = 1'b1;
  logic       sr_wr_en = 1'b0;
  logic [1:0] sr_wr_period = 2'b00;
  logic       sr_wr_wpen = 1'b0;
  logic [1:0] sr_period;
  logic       sr_wpen, reset_out, cmd_block;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  supply_supervisor #(
    .HOLD_MS(HOLD), .PER_LONG(PL), .PER_MID(PM), .PER_SHORT(PS), .PERIOD_RST(2'b00)
  ) u_supply_supervisor (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
    .vcc_above_min(vcc_above_min), .vcc_above_trip(vcc_above_trip),
    .cs_wdi_pin(cs_wdi_pin), .wp_pin(wp_pin),
    .sr_wr_en(sr_wr_en), .sr_wr_period(sr_wr_period), .sr_wr_wpen(sr_wr_wpen),
    .sr_period(sr_period), .sr_wpen(sr_wpen),
    .reset_out(reset_out), .cmd_block(cmd_block)
  );

  task automatic chk(input int got, input int exp, input string req, input string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic chk_rst(input int exp, input string req, input string what);
    #1;
    chk(reset_out, exp, req, what);
    chk(cmd_block, exp, "R4", {what, " blocked flag"});
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1'b1;
      @(negedge clk);
      ms_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sr_write(input logic [1:0] p, input logic w);
    sr_wr_en = 1'b1; sr_wr_period = p; sr_wr_wpen = w;
    @(negedge clk);
    sr_wr_en = 1'b0;
    #1;
  endtask

  task automatic glitch();
    vcc_above_trip = 1'b0;
    @(negedge clk);
    vcc_above_trip = 1'b1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 / R7 reset state
    idle(3);
    chk_rst(1, "R1", "held in rst_n");
    chk(sr_period, 0, "R7", "reset period");
    chk(sr_wpen, 0, "R7", "reset wpen");
    rst_n = 1'b1;
    @(negedge clk);

    // R1 below-minimum with trip high
    vcc_above_min = 1'b0;
    ticks(HOLD + 2);
    chk_rst(1, "R1", "below minimum");
    vcc_above_min = 1'b1;
    @(negedge clk);

    // R2 qualification
    ticks(HOLD - 1);
    chk_rst(1, "R2", "one tick short of hold");
    ticks(1);
    chk_rst(0, "R2", "released after hold");

    // R3 immediate drop and restart
    vcc_above_trip = 1'b0;
    chk_rst(1, "R3", "same-cycle drop");
    @(negedge clk);
    vcc_above_trip = 1'b1;
    ticks(2);
    glitch();
    ticks(HOLD - 1);
    chk_rst(1, "R3", "count restarted by glitch");
    ticks(1);
    chk_rst(0, "R3", "released after full recount");

    // R6 / R8 / R9 period sweep
    for (int s = 0; s < 4; s++) begin
      int lim;
      lim = (s == 0) ? PL : (s == 1) ? PM : (s == 2) ? PS : 0;
      glitch();
      sr_write(s[1:0], 1'b0);
      chk(sr_period, s, "R7", "period written");
      ticks(HOLD);
      chk_rst(0, "R9", "no timeout during hold");
      if (lim == 0) begin
        ticks(3 * PL);
        chk_rst(0, "R6", "disabled never fires");
      end else begin
        ticks(lim - 1);
        chk_rst(0, "R6", "one tick before timeout");
        ticks(1);
        chk_rst(1, "R8", "timeout asserts reset");
        ticks(HOLD - 1);
        chk_rst(1, "R8", "expiry hold not finished");
        ticks(1);
        chk_rst(0, "R8", "expiry hold done");
        ticks(lim - 1);
        chk_rst(0, "R8", "count restarted from zero");
        ticks(1);
        chk_rst(1, "R8", "second timeout");
      end
    end

    // R5 kick edges, mid period
    glitch();
    sr_write(2'b01, 1'b0);
    ticks(HOLD);
    ticks(PM - 1);
    cs_wdi_pin = 1'b0;
    idle(5);
    ticks(PM - 1);
    chk_rst(0, "R5", "falling edge restarted count");
    cs_wdi_pin = 1'b1;
    idle(5);
    ticks(1);
    chk_rst(1, "R5", "rising edge did not restart");
    glitch();
    ticks(HOLD);
    idle(20);
    ticks(PM);
    chk_rst(1, "R5", "static level no kick");

    // R7 lock
    wp_pin = 1'b0;
    sr_write(2'b10, 1'b1);
    chk(sr_period, 2, "R7", "write with wpen clear");
    chk(sr_wpen, 1, "R7", "wpen set");
    sr_write(2'b00, 1'b0);
    chk(sr_period, 2, "R7", "locked period ignored");
    chk(sr_wpen, 1, "R7", "locked wpen ignored");
    wp_pin = 1'b1;
    sr_write(2'b11, 1'b1);
    chk(sr_period, 3, "R7", "pin high unlocks");
    sr_write(2'b01, 1'b0);
    chk(sr_wpen, 0, "R7", "wpen cleared when unlocked");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule